// File: doc/BRIEF.md
# USB Host Controller Command Register

This block holds the command word of a USB host controller and the control behaviour tied to its bits. Software reaches it through a small register bus with write strobe, read strobe, address and data. Address 0 holds the command word. Address 1 returns the byte captured in loopback test mode. The other addresses read as zero. The block drives the controller's control lines: run, transaction enable, global reset, controller reset, global suspend, resume drive, end-of-packet request, loopback and the large-packet select.

Several bits change without a software write. In single-step debug mode the run bit drops after every finished transaction. A wake event seen during global suspend raises the resume bit. When software clears the resume bit, it keeps reading 1 until the line logic reports that the low-speed end-of-packet is done. The block also derives a halted flag. It records in a sticky error flag any attempt to suspend while running.

Top module: `usb_cmd_reg`

## Requirements
- R1: After reset the command word reads 0000h, and bits 15:9 of address 0 always read 0.
- R2: A write to address 0 stores run (bit 0), suspend (bit 3), resume (bit 4), debug (bit 5), a software flag (bit 6), packet select (bit 7) and loopback (bit 8), subject to R4, R5, R8 and R10. A read of address 0 returns them at the same positions. `run_o` follows bit 0. Bit 6 drives no output.
- R3: `maxpkt64_o` follows bit 7: 0 selects 32-byte and 1 selects 64-byte reclamation packets. `lpbk_o` follows bit 8.
- R4: While bit 5 is 1, a `txn_done` pulse clears run in the next cycle, unless a write to address 0 lands in the same cycle.
- R5: A write to address 0 changes bit 5 only when `halted_o` is 1.
- R6: `halted_o` is 1 exactly when run is 0 and `txn_busy` is 0.
- R7: While suspend is 1, a `wake_evt` sets the resume bit in the next cycle. `resume_drv_o` is 1 when the resume bit is 1 and no end-of-packet is pending.
- R8: Writing 0 to bit 4 while it is 1 raises `eop_o`. Bit 4 then reads 1 until the cycle after `eop_done`, when both bit 4 and `eop_o` clear.
- R9: `txn_en_o` is 1 only when run is 1, suspend is 0 and global reset is 0.
- R10: A write with bit 3 set while run is 1 leaves suspend unchanged and sets `susp_err_o`. The flag clears only on reset, controller reset or global reset.
- R11: A write with bit 2 set clears all other state, including the loopback byte and the error flag. It leaves only bit 2 set, and `greset_o` stays 1 until bit 2 is written 0.
- R12: A write with bit 1 set clears all state the same way. Bit 1 and `hcreset_o` read 1 for one cycle and then clear by themselves.
- R13: `lb_data` is captured into address 1 on `lb_valid` only while bit 8 is 1. Otherwise the stored byte is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, zero when not reading |
| txn_done | input | 1 | Transaction finished pulse |
| txn_busy | input | 1 | Transaction in progress |
| wake_evt | input | 1 | Connect, disconnect or K-state detected |
| eop_done | input | 1 | Low-speed end-of-packet finished |
| lb_valid | input | 1 | Loopback data strobe |
| lb_data | input | 8 | Loopback data seen on the peer port |
| run_o | output | 1 | Run state |
| txn_en_o | output | 1 | Transactions may be issued |
| greset_o | output | 1 | Drive global reset on the bus |
| hcreset_o | output | 1 | Controller reset pulse |
| suspend_o | output | 1 | Global suspend active |
| resume_drv_o | output | 1 | Drive global resume signalling |
| eop_o | output | 1 | End-of-packet requested |
| lpbk_o | output | 1 | Loopback test mode |
| maxpkt64_o | output | 1 | 64-byte reclamation packets |
| halted_o | output | 1 | Controller halted |
| susp_err_o | output | 1 | Sticky illegal-suspend flag |

## Verification
Random writes mix the self-clearing and clearing bits, the suspend request and the resume bit with random transaction, wake and end-of-packet pulses. This separates write-wins ordering from the autonomous clears and sets. Directed runs cover the single-step clear against a debug-bit write made while busy, a wake event with and without suspend, and a resume clear held across several cycles without `eop_done`. They also cover a suspend request while running, loopback capture with the mode on and off, and both reset bits, so that a global reset that holds can be told apart from a controller reset that pulses.

// File: rtl/usb_cmd_pkg.sv
// Package: bit positions of the command word shared by the register blocks.
// Assumes the command word fits in the low 9 bits of the data bus.
package usb_cmd_pkg;
    localparam int B_RUN   = 0;
    localparam int B_HCRST = 1;
    localparam int B_GRST  = 2;
    localparam int B_SUSP  = 3;
    localparam int B_RES   = 4;
    localparam int B_DBG   = 5;
    localparam int B_FLAG  = 6;
    localparam int B_MPS   = 7;
    localparam int B_LPBK  = 8;
    localparam int CMD_BITS = 9;
endpackage

// File: rtl/usb_cmd_run_ctl.sv
// Run and debug control: holds run/stop and the single-step debug bit,
// and derives the halted flag. Assumes clr comes only with a command write.
module usb_cmd_run_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic wr_cmd,
    input  logic wr_run,
    input  logic wr_dbg,
    input  logic txn_done,
    input  logic txn_busy,
    output logic run,
    output logic dbg,
    output logic halted
);
    // Halted: stopped and nothing on the wire.
    always_comb halted = !run && !txn_busy;

    // Run/debug state: a write wins over the single-step clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            run <= 1'b0;
            dbg <= 1'b0;
        end else if (wr_cmd) begin
            run <= wr_run;
            if (halted) dbg <= wr_dbg;
        end else if (dbg && txn_done) begin
            run <= 1'b0;
        end
    end

    // R4: single-step clears run after a finished transaction
    assert_step_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg && txn_done && !wr_cmd) |=> !run);

    // R5: debug bit is frozen unless halted
    assert_dbg_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && !clr && !halted) |=> (dbg == $past(dbg)));
endmodule

// File: rtl/usb_cmd_resume_ctl.sv
// Resume control: the resume bit is set by software or by a wake event
// during suspend. A software clear is held until the end-of-packet completes.
module usb_cmd_resume_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic wr_cmd,
    input  logic wr_res,
    input  logic susp,
    input  logic wake,
    input  logic eop_done,
    output logic res_bit,
    output logic eop_busy,
    output logic drive
);
    // Resume drive: only while no end-of-packet is pending.
    always_comb drive = res_bit && !eop_busy;

    // Resume/EOP state: pending EOP first, then writes, then wake events.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            res_bit  <= 1'b0;
            eop_busy <= 1'b0;
        end else if (eop_busy) begin
            if (eop_done) begin
                res_bit  <= 1'b0;
                eop_busy <= 1'b0;
            end
        end else if (wr_cmd && wr_res) begin
            res_bit <= 1'b1;
        end else if (wr_cmd && res_bit) begin
            eop_busy <= 1'b1;
        end else if (susp && wake) begin
            res_bit <= 1'b1;
        end
    end

    // R7: a wake event in suspend raises resume
    assert_wake_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (susp && wake && !res_bit && !wr_cmd) |=> res_bit);

    // R8: resume keeps reading 1 until the EOP is done
    assert_eop_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eop_busy && !eop_done && !clr) |=> (res_bit && eop_busy));
endmodule

// File: rtl/usb_cmd_lpbk_cap.sv
// Loopback capture: stores the peer port's data while loopback is on.
module usb_cmd_lpbk_cap #(
    parameter int LB_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            en,
    input  logic            valid,
    input  logic [LB_W-1:0] din,
    output logic [LB_W-1:0] dout
);
    // Capture register: loads only in loopback mode.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) dout <= '0;
        else if (en && valid) dout <= din;
    end

    // R13: nothing is captured with loopback off
    assert_lb_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(dout));
endmodule

// File: rtl/usb_cmd_reg.sv
// Command register top: decodes the bus, holds the remaining command bits
// and the suspend error flag, and assembles the read data.
// Assumes LB_W <= DATA_W and the command word fits DATA_W.
module usb_cmd_reg #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 2,
    parameter int LB_W   = 8,
    parameter logic [ADDR_W-1:0] CMD_ADDR = 0,
    parameter logic [ADDR_W-1:0] LBD_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              txn_done,
    input  logic              txn_busy,
    input  logic              wake_evt,
    input  logic              eop_done,
    input  logic              lb_valid,
    input  logic [LB_W-1:0]   lb_data,
    output logic              run_o,
    output logic              txn_en_o,
    output logic              greset_o,
    output logic              hcreset_o,
    output logic              suspend_o,
    output logic              resume_drv_o,
    output logic              eop_o,
    output logic              lpbk_o,
    output logic              maxpkt64_o,
    output logic              halted_o,
    output logic              susp_err_o
);
    import usb_cmd_pkg::*;

    localparam int RSVD_W = DATA_W - CMD_BITS;

    logic sel_w, clr;
    logic hcr, grst, susp, flag, mps, lpbk, err;
    logic run, dbg, res_bit;
    logic [LB_W-1:0] lb_q;
    logic [CMD_BITS-1:0] cmd_word;

    // Bus decode: command write, and the clearing resets carried by it.
    always_comb begin
        sel_w = bus_wr && (bus_addr == CMD_ADDR);
        clr   = sel_w && (bus_wdata[B_HCRST] || bus_wdata[B_GRST]);
    end

    // Plain command bits, reset bits and the sticky suspend error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {hcr, grst, susp, flag, mps, lpbk, err} <= '0;
        end else if (clr) begin
            {susp, flag, mps, lpbk, err} <= '0;
            hcr  <= bus_wdata[B_HCRST];
            grst <= bus_wdata[B_GRST];
        end else begin
            hcr <= 1'b0;
            if (sel_w) begin
                grst <= bus_wdata[B_GRST];
                flag <= bus_wdata[B_FLAG];
                mps  <= bus_wdata[B_MPS];
                lpbk <= bus_wdata[B_LPBK];
                if (bus_wdata[B_SUSP] && run) err <= 1'b1;
                else susp <= bus_wdata[B_SUSP];
            end
        end
    end

    usb_cmd_run_ctl u_run (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_cmd(sel_w),
        .wr_run(bus_wdata[B_RUN]), .wr_dbg(bus_wdata[B_DBG]),
        .txn_done(txn_done), .txn_busy(txn_busy),
        .run(run), .dbg(dbg), .halted(halted_o)
    );

    usb_cmd_resume_ctl u_res (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_cmd(sel_w),
        .wr_res(bus_wdata[B_RES]), .susp(susp), .wake(wake_evt),
        .eop_done(eop_done), .res_bit(res_bit), .eop_busy(eop_o),
        .drive(resume_drv_o)
    );

    usb_cmd_lpbk_cap #(.LB_W(LB_W)) u_lb (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(lpbk),
        .valid(lb_valid), .din(lb_data), .dout(lb_q)
    );

    // Output mapping and read mux.
    always_comb begin
        cmd_word = {lpbk, mps, flag, dbg, res_bit, susp, grst, hcr, run};
        run_o      = run;
        txn_en_o   = run && !susp && !grst;
        greset_o   = grst;
        hcreset_o  = hcr;
        suspend_o  = susp;
        lpbk_o     = lpbk;
        maxpkt64_o = mps;
        susp_err_o = err;
        bus_rdata  = '0;
        if (bus_rd && bus_addr == CMD_ADDR)
            bus_rdata = {{RSVD_W{1'b0}}, cmd_word};
        else if (bus_rd && bus_addr == LBD_ADDR)
            bus_rdata = {{(DATA_W-LB_W){1'b0}}, lb_q};
    end

    // R1: reserved bits never read back as 1
    assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == CMD_ADDR) |-> (bus_rdata[DATA_W-1:CMD_BITS] == '0));

    // R10: suspend request while running is refused and flagged
    assert_susp_refused_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_w && !clr && bus_wdata[B_SUSP] && run_o) |=>
        (suspend_o == $past(suspend_o)) && susp_err_o);

    // R12: controller reset bit clears itself
    assert_hcr_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (hcreset_o && !clr) |=> !hcreset_o);

    // R9: no transactions while suspended
    assert_no_txn_susp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_o |-> !txn_en_o);
endmodule

// File: tb/usb_cmd_reg_bench.sv
module usb_cmd_reg_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 0, bus_rd = 0;
    logic [1:0] bus_addr = 0;
    logic [15:0] bus_wdata = 0;
    logic [15:0] bus_rdata;
    logic txn_done = 0, txn_busy = 0, wake_evt = 0, eop_done = 0, lb_valid = 0;
    logic [7:0] lb_data = 0;
    logic run_o, txn_en_o, greset_o, hcreset_o, suspend_o, resume_drv_o;
    logic eop_o, lpbk_o, maxpkt64_o, halted_o, susp_err_o;

    int vectors = 0, misses = 0;
    bit finished = 0;

    // model state
    bit m_run, m_hcr, m_gr, m_sus, m_res, m_dbg, m_flag, m_mp, m_lb, m_eop, m_err;
    bit [7:0] m_lbd;

    always #10 clk = ~clk;

    usb_cmd_reg u_usb_cmd_reg (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .txn_done(txn_done), .txn_busy(txn_busy), .wake_evt(wake_evt),
        .eop_done(eop_done), .lb_valid(lb_valid), .lb_data(lb_data),
        .run_o(run_o), .txn_en_o(txn_en_o), .greset_o(greset_o),
        .hcreset_o(hcreset_o), .suspend_o(suspend_o),
        .resume_drv_o(resume_drv_o), .eop_o(eop_o), .lpbk_o(lpbk_o),
        .maxpkt64_o(maxpkt64_o), .halted_o(halted_o), .susp_err_o(susp_err_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit [15:0] exp_rdata(input bit rd, input bit [1:0] a);
        if (!rd) return 16'h0;
        if (a == 2'd0)
            return {7'b0, m_lb, m_mp, m_flag, m_dbg, m_res, m_sus, m_gr, m_hcr, m_run};
        if (a == 2'd1) return {8'h0, m_lbd};
        return 16'h0;
    endfunction

    function automatic bit exp_halted(input bit busy);
        return !m_run && !busy;
    endfunction

    // One cycle: drive at the falling edge, compare, advance model at rise.
    task automatic cyc(input bit wr, input bit rd, input bit [1:0] a, input bit [15:0] wd,
                       input bit done, input bit busy, input bit wk, input bit ed,
                       input bit lv, input bit [7:0] ld);
        bit sel, clr, hlt;
        bit n_run, n_hcr, n_gr, n_sus, n_res, n_dbg, n_flag, n_mp, n_lb, n_eop, n_err;
        bit [7:0] n_lbd;
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        txn_done = done; txn_busy = busy; wake_evt = wk; eop_done = ed;
        lb_valid = lv; lb_data = ld;
        #1;
        chk("R2 rdata", bus_rdata, exp_rdata(rd, a));
        if (rd && a == 2'd0) chk("R1 reserved", {9'b0, bus_rdata[15:9]}, 16'h0);
        chk("R5 dbg", {15'b0, u_dbg_view(rd, a)}, {15'b0, (rd && a == 2'd0) ? m_dbg : 1'b0});
        chk("R4 run", {15'b0, run_o}, {15'b0, m_run});
        chk("R9 txn_en", {15'b0, txn_en_o}, {15'b0, m_run && !m_sus && !m_gr});
        chk("R11 greset", {15'b0, greset_o}, {15'b0, m_gr});
        chk("R12 hcreset", {15'b0, hcreset_o}, {15'b0, m_hcr});
        chk("R10 suspend", {15'b0, suspend_o}, {15'b0, m_sus});
        chk("R10 err", {15'b0, susp_err_o}, {15'b0, m_err});
        chk("R7 resume_drv", {15'b0, resume_drv_o}, {15'b0, m_res && !m_eop});
        chk("R8 eop", {15'b0, eop_o}, {15'b0, m_eop});
        chk("R3 lpbk", {15'b0, lpbk_o}, {15'b0, m_lb});
        chk("R3 maxpkt", {15'b0, maxpkt64_o}, {15'b0, m_mp});
        chk("R6 halted", {15'b0, halted_o}, {15'b0, exp_halted(busy)});

        sel = wr && (a == 2'd0);
        clr = sel && (wd[1] || wd[2]);
        hlt = exp_halted(busy);
        {n_run, n_hcr, n_gr, n_sus, n_res, n_dbg, n_flag, n_mp, n_lb, n_eop, n_err} =
            {m_run, 1'b0, m_gr, m_sus, m_res, m_dbg, m_flag, m_mp, m_lb, m_eop, m_err};
        n_lbd = m_lbd;
        if (clr) begin
            {n_run, n_sus, n_res, n_dbg, n_flag, n_mp, n_lb, n_eop, n_err} = '0;
            n_hcr = wd[1]; n_gr = wd[2]; n_lbd = 0;
        end else begin
            if (sel) begin
                n_run = wd[0]; n_gr = wd[2]; n_flag = wd[6]; n_mp = wd[7]; n_lb = wd[8];
                if (wd[3] && m_run) n_err = 1; else n_sus = wd[3];
                if (hlt) n_dbg = wd[5];
            end else if (m_dbg && done) n_run = 0;
            if (m_eop) begin
                if (ed) begin n_res = 0; n_eop = 0; end
            end else if (sel && wd[4]) n_res = 1;
            else if (sel && m_res) n_eop = 1;
            else if (m_sus && wk) n_res = 1;
            if (m_lb && lv) n_lbd = ld;
        end
        @(posedge clk);
        {m_run, m_hcr, m_gr, m_sus, m_res, m_dbg, m_flag, m_mp, m_lb, m_eop, m_err} =
            {n_run, n_hcr, n_gr, n_sus, n_res, n_dbg, n_flag, n_mp, n_lb, n_eop, n_err};
        m_lbd = n_lbd;
    endtask

    function automatic bit u_dbg_view(input bit rd, input bit [1:0] a);
        return (rd && a == 2'd0) ? bus_rdata[5] : 1'b0;
    endfunction

    task automatic wr0(input bit [15:0] wd);
        cyc(1, 1, 0, wd, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        void'($urandom(32'h1357_2468));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset value
        idle(1);
        // R2/R3: plain storage, flag bit has no output
        wr0(16'h01C0); idle(1); wr0(16'h0000);
        // R4: single-step debug
        wr0(16'h0021); cyc(0, 1, 0, 0, 1, 1, 0, 0, 0, 0); idle(1);
        // R5: debug write refused while running or busy
        wr0(16'h0001); wr0(16'h0020); wr0(16'h0000);
        cyc(1, 1, 0, 16'h0020, 0, 1, 0, 0, 0, 0); idle(1);
        // R10: suspend while running
        wr0(16'h0001); wr0(16'h0009); idle(1);
        // R7: wake without suspend, then in suspend
        wr0(16'h0000); cyc(0, 1, 0, 0, 0, 0, 1, 0, 0, 0);
        wr0(16'h0008); cyc(0, 1, 0, 0, 0, 0, 1, 0, 0, 0);
        // R8: clear resume, EOP held then done
        wr0(16'h0008); idle(3); cyc(0, 1, 0, 0, 0, 0, 0, 1, 0, 0); idle(1);
        // R13: loopback off then on
        cyc(0, 1, 1, 0, 0, 0, 0, 0, 1, 8'hA5);
        wr0(16'h0100); cyc(0, 1, 1, 0, 0, 0, 0, 0, 1, 8'h3C); cyc(0, 1, 1, 0, 0, 0, 0, 0, 0, 0);
        // R12: controller reset pulse
        wr0(16'h0002); idle(2);
        // R11: global reset holds
        wr0(16'h0101); cyc(0, 1, 0, 0, 0, 0, 0, 0, 1, 8'h77);
        wr0(16'h0004); idle(2); cyc(0, 1, 1, 0, 0, 0, 0, 0, 0, 0); wr0(16'h0000);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            bit [15:0] wd = 16'($urandom);
            bit [1:0] a = ($urandom % 4 == 0) ? 2'($urandom) : 2'd0;
            if ($urandom % 12 != 0) wd[2:1] = 2'b00;
            if ($urandom % 3 == 0) wd[0] = 0;
            cyc(($urandom % 3) == 0, ($urandom % 4) != 0, a, wd,
                ($urandom % 3) == 0, ($urandom % 3) == 0, ($urandom % 4) == 0,
                ($urandom % 4) == 0, ($urandom % 2) == 0, 8'($urandom));
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            misses++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule